// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator with Phase Trim

This block turns a fixed master clock into a periodic sample strobe. Its rate is set in whole hertz. Every master-clock cycle, a phase accumulator adds the programmed rate word. The accumulator counts modulo the master-clock frequency (24,576,000 by default), so one count of the rate word is one hertz of strobe rate. Each time the accumulator wraps, the block raises a one-cycle strobe.

A second register trims the strobe phase without changing its rate. Software writes a direction and a magnitude. The block then works off the magnitude one step per trim tick, where one trim tick is every eighth master cycle. Each step moves the accumulator by 1/3000 of its modulus, which is 0.12 degrees of a sample period. Reading the trim register shows how many steps are still pending.

Registers are written and read through a plain parallel write-enable, address and data port:

| Address | Register | Layout |
|---|---|---|
| 0 | Rate | bits 15:0 hold the rate in hertz |
| 1 | Trim | bit 8 holds the direction, bits 7:0 hold the magnitude |

Both the reset input and the power-down input are active low. While either is low, the registers sit at their defaults.

Top module: `srt_tick_gen`

## Requirements
- R1: After reset, reading address 0 returns 0xBB80, reading address 1 returns 0x0000 and the strobe is low. With the default rate, the first strobe appears in the 512th cycle after reset releases.
- R2: After N clock edges with rate R and no trim, counting from a cleared accumulator, exactly floor(sum of added rates / 24,576,000) strobes have occurred. Each strobe lasts exactly one cycle.
- R3: A write to address 0 stores the rate. A value below 0x0FA0 is stored as 0x0FA0, and a value above 0xD2F0 is stored as 0xD2F0. Reading address 0 returns the stored value.
- R4: While rst_n or pd_n is low, both registers hold their defaults and writes to them have no effect. The accumulator stays cleared and no strobe is produced.
- R5: A write to address 1 loads the trim direction from wdata bit 8 (0 advances, 1 retards) and the magnitude from wdata bits 7:0. Reading address 1 returns the direction in bit 8 and the remaining magnitude in bits 7:0.
- R6: The pending magnitude drops by exactly one on each trim tick. Trim ticks occur every 8 master cycles. No step is taken once the magnitude reaches zero.
- R7: An advance step adds 8192 to the accumulator and a retard step subtracts 8192, so that pending trim moves the strobe earlier or later by that amount.
- R8: A retard step that would take the accumulator below zero is held back until a later tick. As a result, trim never produces a duplicate strobe and never loses one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_n | input | 1 | Power-down, active low; holds registers at defaults |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select (0 selects rate, 1 selects trim); also selects readback |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Readback of the selected register |
| strobe | output | 1 | One-cycle sample strobe |

## Verification
The bench uses the default parameters:
- a modulus of 24,576,000,
- rate limits of 4000 and 54000,
- a trim step of 8192,
- a trim tick every 8 cycles.

At the default rate of 48,000 Hz, the strobe period is exactly 512 cycles. This makes the position of the first strobe after reset or power-down exactly predictable.

For the rate and clamping tests, the bench counts strobes over 10,000-cycle windows. These windows are long enough to show the floor count at both ends of the clamped range.

For the trim tests, the bench chooses window lengths that place a strobe boundary inside the 2,088,960 total shift of 255 steps. An advance trim of 255 steps therefore gains exactly one strobe, and a retard trim of 255 steps loses exactly one.

// File: rtl/srt_pkg.sv
// Shared definitions for the sample-rate strobe generator.
// Assumes a two-entry register map selected by a one-bit address.
package srt_pkg;
    typedef enum logic {
        TRIM_ADV = 1'b0,
        TRIM_RET = 1'b1
    } trim_dir_e;

    localparam logic ADDR_RATE = 1'b0;
    localparam logic ADDR_TRIM = 1'b1;
endpackage

// File: rtl/srt_rate_reg.sv
// Rate register: stores the strobe rate in hertz, clamped to [RATE_MIN, RATE_MAX].
// Assumes RATE_MIN <= RATE_RST <= RATE_MAX < 2**RATE_W.
// Held at RATE_RST while rst_n or pd_n is low, and writes are ignored then.
module srt_rate_reg #(
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned RATE_MIN = 4000,
    parameter int unsigned RATE_MAX = 54000,
    parameter int unsigned RATE_RST = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              wr,
    input  logic [RATE_W-1:0] wdata,
    output logic [RATE_W-1:0] rate_q
);
    localparam logic [RATE_W-1:0] LO  = RATE_W'(RATE_MIN);
    localparam logic [RATE_W-1:0] HI  = RATE_W'(RATE_MAX);
    localparam logic [RATE_W-1:0] DEF = RATE_W'(RATE_RST);

    logic [RATE_W-1:0] clamped;

    // Limit the written value to the usable range.
    always_comb begin
        if (wdata < LO)      clamped = LO;
        else if (wdata > HI) clamped = HI;
        else                 clamped = wdata;
    end

    // Hold the default during reset or power-down; otherwise accept writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) rate_q <= DEF;
        else if (wr)         rate_q <= clamped;
    end

    AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_q >= LO) && (rate_q <= HI)); // R3
    AST_PD_HOLDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (rate_q == DEF)); // R4
endmodule

// File: rtl/srt_trim_ctl.sv
// Trim controller: holds the trim direction and pending magnitude. A free-running
// prescaler raises a tick every DIV cycles. On a tick with magnitude left, it
// requests one step and decrements once the accumulator accepts the step.
// A load in the same cycle as a tick takes priority, and that tick is dropped.
module srt_trim_ctl
    import srt_pkg::*;
#(
    parameter int unsigned MAG_W = 8,
    parameter int unsigned DIV   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             load,
    input  trim_dir_e        load_dir,
    input  logic [MAG_W-1:0] load_mag,
    input  logic             step_ok,
    output logic             step_req,
    output trim_dir_e        dir_q,
    output logic [MAG_W-1:0] mag_q
);
    localparam int unsigned PS_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV - 1);

    logic [PS_W-1:0] ps_q;
    logic            tick;

    assign tick     = (ps_q == PS_LAST);
    assign step_req = tick && (mag_q != '0) && !load;

    // Free-running prescaler that marks every DIV-th cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) ps_q <= '0;
        else if (tick)       ps_q <= '0;
        else                 ps_q <= ps_q + 1'b1;
    end

    // Trim register: a load replaces it, and each accepted step uses one count.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            dir_q <= TRIM_ADV;
            mag_q <= '0;
        end else if (load) begin
            dir_q <= load_dir;
            mag_q <= load_mag;
        end else if (step_req && step_ok) begin
            mag_q <= mag_q - 1'b1;
        end
    end

    AST_TRIM_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
        ((mag_q != $past(mag_q)) && !$past(load)) |-> (mag_q == $past(mag_q) - 1'b1)); // R6
    AST_TRIM_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
        (($past(mag_q) == '0) && !$past(load)) |-> (mag_q == '0)); // R6
endmodule

// File: rtl/srt_phase_acc.sv
// Phase accumulator: each cycle adds the rate word modulo CLK_HZ and raises a
// one-cycle strobe on every wrap. An accepted trim step adds or subtracts STEP
// in the same cycle. A retard step that would borrow below zero is refused, so
// the trim controller retries it on a later tick.
// Assumes RATE_MAX + STEP < CLK_HZ, so that a cycle wraps at most once.
module srt_phase_acc
    import srt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 24_576_000,
    parameter int unsigned RATE_W = 16,
    parameter int unsigned STEP   = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              step_req,
    input  trim_dir_e         step_dir,
    output logic              step_ok,
    output logic              strobe
);
    localparam int unsigned ACC_W = $clog2(CLK_HZ);
    localparam int unsigned SUM_W = ACC_W + 1;
    localparam logic [SUM_W-1:0] MOD_V  = SUM_W'(CLK_HZ);
    localparam logic [SUM_W-1:0] STEP_V = SUM_W'(STEP);

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] base, trimmed, wrapped;
    logic             wrap;

    // Form the next phase: rate increment, optional trim step, then modulo.
    always_comb begin
        base    = {1'b0, acc_q} + {{(SUM_W-RATE_W){1'b0}}, rate};
        step_ok = 1'b0;
        trimmed = base;
        if (step_req) begin
            if (step_dir == TRIM_ADV) begin
                trimmed = base + STEP_V;
                step_ok = 1'b1;
            end else if (base >= STEP_V) begin
                trimmed = base - STEP_V;
                step_ok = 1'b1;
            end
        end
        wrap    = (trimmed >= MOD_V);
        wrapped = wrap ? (trimmed - MOD_V) : trimmed;
    end

    // Register the phase and the wrap strobe; both are cleared in reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            acc_q  <= '0;
            strobe <= 1'b0;
        end else begin
            acc_q  <= wrapped[ACC_W-1:0];
            strobe <= wrap;
        end
    end

    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, acc_q} < MOD_V)); // R2
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
        strobe |=> !strobe); // R2
    AST_STROBE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
        strobe |-> (acc_q < $past(acc_q))); // R8
    AST_PD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !strobe); // R4
endmodule

// File: rtl/srt_tick_gen.sv
// Top of the sample-rate strobe generator. Decodes register writes, provides
// combinational readback of the selected register, and links the rate
// register, trim controller and phase accumulator.
// Register layout: address 0 holds the rate; address 1 holds the trim
// direction in bit MAG_W and the trim magnitude in bits MAG_W-1:0.
module srt_tick_gen
    import srt_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 24_576_000,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned RATE_MIN = 4000,
    parameter int unsigned RATE_MAX = 54000,
    parameter int unsigned RATE_RST = 48000,
    parameter int unsigned MAG_W    = 8,
    parameter int unsigned TRIM_DIV = 8,
    parameter int unsigned STEPS_PER_PERIOD = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              strobe
);
    localparam int unsigned STEP  = CLK_HZ / STEPS_PER_PERIOD;
    localparam int unsigned PAD_W = DATA_W - MAG_W - 1;

    logic              wr_rate, wr_trim;
    logic [DATA_W-1:0] rate_q;
    logic              step_req, step_ok;
    trim_dir_e         dir_q;
    logic [MAG_W-1:0]  mag_q;

    assign wr_rate = wr_en && (addr == ADDR_RATE);
    assign wr_trim = wr_en && (addr == ADDR_TRIM);

    // Return the register that addr selects.
    always_comb begin
        if (addr == ADDR_TRIM) rdata = {{PAD_W{1'b0}}, dir_q, mag_q};
        else                   rdata = rate_q;
    end

    srt_rate_reg #(
        .RATE_W  (DATA_W),
        .RATE_MIN(RATE_MIN),
        .RATE_MAX(RATE_MAX),
        .RATE_RST(RATE_RST)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_n  (pd_n),
        .wr    (wr_rate),
        .wdata (wdata),
        .rate_q(rate_q)
    );

    srt_trim_ctl #(
        .MAG_W(MAG_W),
        .DIV  (TRIM_DIV)
    ) u_trim (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .load    (wr_trim),
        .load_dir(trim_dir_e'(wdata[MAG_W])),
        .load_mag(wdata[MAG_W-1:0]),
        .step_ok (step_ok),
        .step_req(step_req),
        .dir_q   (dir_q),
        .mag_q   (mag_q)
    );

    srt_phase_acc #(
        .CLK_HZ(CLK_HZ),
        .RATE_W(DATA_W),
        .STEP  (STEP)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .rate    (rate_q),
        .step_req(step_req),
        .step_dir(dir_q),
        .step_ok (step_ok),
        .strobe  (strobe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!strobe && (mag_q == '0))); // R1
endmodule

// File: tb/test_srt_tick_gen.sv
// Self-checking bench for srt_tick_gen: a table of rate writes with expected
// strobe counts, then directed tests for reset, power-down and trim.
module test_srt_tick_gen;
    localparam longint MODV = 24_576_000;
    localparam longint STEPV = 8192;
    localparam int     WIN = 10000;
    localparam logic [15:0] RATE_VEC [8] = '{16'h0FA0, 16'hD2F0, 16'h0000, 16'hFFFF,
                                             16'hAC44, 16'h0FA1, 16'h7D00, 16'hD2F1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        strobe;

    int tests = 0;
    int fails = 0;

    srt_tick_gen i_srt_tick_gen (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .strobe(strobe)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input longint got, input longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint clamp_rate(input longint v);
        if (v < 4000) return 4000;
        if (v > 54000) return 54000;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pd_n  = 1'b1;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    // Count strobes over n edges and count back-to-back strobe samples.
    task automatic count_strobes(input int n, output int cnt, output int dbl);
        logic prev = 1'b0;
        cnt = 0;
        dbl = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (strobe) cnt++;
            if (strobe && prev) dbl++;
            prev = strobe;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int c1, c2, d1, d2;

        // R1: reset state
        do_reset();
        rd(1'b0, v); check("R1 rate reset", v, 16'hBB80);
        rd(1'b1, v); check("R1 trim reset", v, 0);
        check("R1 strobe low", strobe, 0);
        count_strobes(511, c1, d1); check("R1 no strobe before 512", c1, 0);
        count_strobes(1, c1, d1);   check("R1 strobe at 512", c1, 1);

        // R2/R3: rate table walk
        for (int i = 0; i < 8; i++) begin
            longint r;
            r = clamp_rate(longint'(RATE_VEC[i]));
            do_reset();
            wr(1'b0, RATE_VEC[i]);
            rd(1'b0, v); check("R3 clamped readback", v, r);
            count_strobes(WIN, c1, d1);
            check("R2 strobe count", c1, (48000 + longint'(WIN) * r) / MODV);
            check("R2 one-cycle strobe", d1, 0);
        end

        // R4: power-down clears, ignores writes, silences strobe
        do_reset();
        wr(1'b0, 16'h7D00);
        wr(1'b1, 16'h0120);
        pd_n = 1'b0;
        @(negedge clk);
        wr(1'b0, 16'h1234);
        wr(1'b1, 16'h01FF);
        rd(1'b0, v); check("R4 rate held in pd", v, 16'hBB80);
        rd(1'b1, v); check("R4 trim held in pd", v, 0);
        count_strobes(2000, c1, d1); check("R4 no strobe in pd", c1, 0);
        pd_n = 1'b1;
        count_strobes(511, c1, d1); check("R4 cleared phase after pd", c1, 0);
        count_strobes(1, c1, d1);   check("R4 first strobe after pd", c1, 1);

        // R5/R6/R7: advance trim of 255 gains one strobe
        do_reset();
        wr(1'b1, 16'h00FF);
        rd(1'b1, v); check("R5 advance readback", v, 16'h00FF);
        count_strobes(8, c1, d1);
        rd(1'b1, v); check("R6 one step per 8 cycles", v, 16'h00FE);
        count_strobes(3049 - 8, c2, d2);
        check("R7 advance strobe count", c1 + c2,
              (48000 * 3050 + 255 * STEPV) / MODV);
        rd(1'b1, v); check("R6 trim fully consumed", v, 16'h0000);

        // R5/R7/R8: retard trim of 255 loses one strobe, never duplicates
        do_reset();
        wr(1'b1, 16'h01FF);
        rd(1'b1, v); check("R5 retard readback", v, 16'h01FF);
        count_strobes(8, c1, d1);
        rd(1'b1, v); check("R6 retard step per 8 cycles", v, 16'h01FE);
        count_strobes(3079 - 8, c2, d2);
        check("R7 R8 retard strobe count", c1 + c2,
              (48000 * 3080 - 255 * STEPV) / MODV);
        check("R8 no doubled strobe", d1 + d2, 0);
        rd(1'b1, v); check("R8 retard consumed", v, 16'h0100);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule